// File: doc/BRIEF.md
# Programmable System Clock Divider Tree

This block takes one fast oscillator clock and derives four clocks from it. The general system clock divides the oscillator by a power of two. The block has two ways to set that ratio: a normal-mode exponent, and a low-power exponent that always divides by at least two. A bus-rate clock further divides the general clock by a small integer. An external clock output follows the bus-rate clock, but only while it is enabled and the PLL reports lock. A baud-rate reference clock has its own divider, chosen from 1, 4, 16 or 64, and ignores the power mode.

Every derived clock is a registered level in the oscillator domain, paired with a one-cycle tick. The tick marks the cycle in which that clock rises, and logic downstream uses it as a clock enable. The bus stage counts general-clock ticks, so each bus edge comes one oscillator cycle after a general-clock edge. A new ratio, a new mode or a new external enable takes effect only at a rising edge of the clock it controls. This rule keeps short pulses off every output.

Top module: `sysclk_div_tree`

## Requirements
- R1: With `lowpwr_sel`=0, the general clock period is 2^`norm_exp` oscillator cycles. `gen_tick` is high once per period.
- R2: With `lowpwr_sel`=1, the general clock period is 2^(`lp_exp`+1) oscillator cycles, so the ratio is never below 2.
- R3: The bus clock period is (`bus_div`+1) general-clock periods. Every `bus_tick` falls in the cycle directly after a `gen_tick`.
- R4: For a ratio R≥2, the level of a divided clock is high for the first floor(R/2) source periods and low for the rest. An odd bus ratio therefore gives one source period less high than low. For R=1, the level copies the source level, one cycle later for the bus stage. The oscillator source counts as constant high.
- R5: A change to `norm_exp`, `lp_exp`, `lowpwr_sel`, `bus_div` or `baud_sel` is sampled only on the cycle that ends the current period of the affected clock. It applies from the following period.
- R6: While enabled and locked, `ext_clk` equals the bus clock level delayed by one oscillator cycle.
- R7: One cycle after `pll_locked` is low, `ext_clk` and `ext_tick` are low. After lock returns, they stay low until the next bus rising edge.
- R8: A change on `ext_en` takes effect only at a bus rising edge. A period already started on `ext_clk` runs to its end.
- R9: The baud clock period is 4^`baud_sel` oscillator cycles, whatever the values of `lowpwr_sel` and `lp_exp`.
- R10: During reset every output is 0. The first `gen_tick` and `baud_tick` come one cycle after reset is released, and the active ratios start at 1.
- R11: A tick output is one cycle wide. It is high only in a cycle where the matching level output is high. `ext_tick` follows `bus_tick` under the same gating as `ext_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast oscillator clock, the only clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lowpwr_sel | input | 1 | 1 selects the low-power exponent for the general clock |
| norm_exp | input | 3 | Normal-mode divide exponent |
| lp_exp | input | 3 | Low-power divide exponent (ratio 2^(value+1)) |
| bus_div | input | 2 | Bus divide minus one |
| baud_sel | input | 2 | Baud divide select, ratio 4^value |
| ext_en | input | 1 | External clock output enable |
| pll_locked | input | 1 | PLL lock indication, 0 forces the external clock low |
| gen_clk | output | 1 | General clock level |
| gen_tick | output | 1 | General clock rising-edge pulse |
| bus_clk | output | 1 | Bus clock level |
| bus_tick | output | 1 | Bus clock rising-edge pulse |
| ext_clk | output | 1 | Gated external clock level |
| ext_tick | output | 1 | External clock rising-edge pulse |
| baud_clk | output | 1 | Baud reference clock level |
| baud_tick | output | 1 | Baud reference rising-edge pulse |

## Verification
The bench changes ratios and the power mode in the middle of a period. A divider that reloaded at once would shorten the period in progress and emit a runt tick. It also drives ratio 1 at both stages, where a wrong level rule would leave the clock stuck low. It sets the largest low-power exponent, and a design that widened the shift wrongly would wrap it to a tiny ratio. It drops lock while the external clock is high and raises it again mid-period, and disables the output mid-period. A gate that was not aligned to the bus edge would truncate the high phase there, or let it restart partway through a period.

// File: rtl/sysclk_div_pkg.sv
// Shared helpers for the divider tree: mode encoding and ratio-width sizing.
// Assumes exponent fields are small enough that 2^(2^width) fits an int.
package sysclk_div_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOWPWR = 1'b1
    } pwr_mode_e;

    // Bits needed to hold 2^(2^exp_w), the largest general ratio.
    function automatic int gen_ratio_bits(input int exp_w);
        return (1 << exp_w) + 1;
    endfunction

    // Bits needed to hold 4^(2^sel_w - 1), the largest baud ratio.
    function automatic int baud_ratio_bits(input int sel_w);
        return 2 * ((1 << sel_w) - 1) + 1;
    endfunction

endpackage

// File: rtl/clkdiv_stage.sv
// One divider stage. It counts source periods, each announced by in_tick,
// and produces a registered level plus a one-cycle rising-edge tick.
// Assumes ratio >= 1. The ratio is reloaded only when a period wraps.
module clkdiv_stage #(
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_tick,
    input  logic          in_lvl,
    input  logic [RW-1:0] ratio,
    output logic          out_tick,
    output logic          out_lvl
);

    logic [RW-1:0] cnt_q, act_q;
    logic [RW-1:0] cnt_d, act_d;
    logic          wrap;
    logic          lvl_d;

    assign wrap = (cnt_q == act_q - RW'(1));

    // Next count and active ratio; reload the ratio only at a period boundary.
    always_comb begin
        cnt_d = cnt_q;
        act_d = act_q;
        if (in_tick) begin
            if (wrap) begin
                cnt_d = '0;
                act_d = ratio;
            end else begin
                cnt_d = cnt_q + RW'(1);
            end
        end
    end

    // Level for the next cycle: first half of the period high, or copy at ratio 1.
    always_comb begin
        if (act_d == RW'(1)) lvl_d = in_lvl;
        else                 lvl_d = (cnt_d < (act_d >> 1));
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            act_q    <= RW'(1);
            out_tick <= 1'b0;
            out_lvl  <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            act_q    <= act_d;
            out_tick <= in_tick && wrap;
            out_lvl  <= lvl_d;
        end
    end

endmodule

// File: rtl/clkdiv_extgate.sv
// Gates the bus clock onto the external output. Loss of lock clears the
// gate at once. The enable is sampled only at a bus rising edge, so no
// partial period ever reaches the output.
module clkdiv_extgate (
    input  logic clk,
    input  logic rst_n,
    input  logic src_tick,
    input  logic src_lvl,
    input  logic ena,
    input  logic locked,
    output logic ext_lvl,
    output logic ext_tick
);

    logic gate_q;
    logic gate_now;

    // Gate in force this cycle: a fresh enable sample at an edge, else the held one.
    assign gate_now = locked && (src_tick ? ena : gate_q);

    // Hold the gate between bus edges and drop it whenever lock is lost.
    always_ff @(posedge clk) begin
        if (!rst_n)       gate_q <= 1'b0;
        else if (!locked) gate_q <= 1'b0;
        else if (src_tick) gate_q <= ena;
    end

    // Registered gated level and tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_lvl  <= 1'b0;
            ext_tick <= 1'b0;
        end else begin
            ext_lvl  <= gate_now && src_lvl;
            ext_tick <= gate_now && src_tick;
        end
    end

endmodule

// File: rtl/sysclk_div_tree.sv
// Top of the divider tree. The general stage runs off the oscillator, the
// bus stage counts general ticks, the external gate follows the bus stage,
// and the baud stage runs off the oscillator on its own.
// Assumes all inputs are synchronous to clk_vco.
module sysclk_div_tree
    import sysclk_div_pkg::*;
#(
    parameter int EXP_W  = 3,
    parameter int BUS_W  = 2,
    parameter int BAUD_W = 2
) (
    input  logic             clk_vco,
    input  logic             rst_n,
    input  logic             lowpwr_sel,
    input  logic [EXP_W-1:0] norm_exp,
    input  logic [EXP_W-1:0] lp_exp,
    input  logic [BUS_W-1:0] bus_div,
    input  logic [BAUD_W-1:0] baud_sel,
    input  logic             ext_en,
    input  logic             pll_locked,
    output logic             gen_clk,
    output logic             gen_tick,
    output logic             bus_clk,
    output logic             bus_tick,
    output logic             ext_clk,
    output logic             ext_tick,
    output logic             baud_clk,
    output logic             baud_tick
);

    localparam int GEN_RW  = gen_ratio_bits(EXP_W);
    localparam int BUS_RW  = BUS_W + 1;
    localparam int BAUD_RW = baud_ratio_bits(BAUD_W);

    pwr_mode_e          mode;
    logic [GEN_RW-1:0]  gen_ratio;
    logic [BUS_RW-1:0]  bus_ratio;
    logic [BAUD_RW-1:0] baud_ratio;

    assign mode = pwr_mode_e'(lowpwr_sel);

    // Ratio decode for every stage.
    always_comb begin
        if (mode == MODE_LOWPWR) gen_ratio = GEN_RW'(2) << lp_exp;
        else                     gen_ratio = GEN_RW'(1) << norm_exp;
        bus_ratio  = BUS_RW'(bus_div) + BUS_RW'(1);
        baud_ratio = BAUD_RW'(1) << {baud_sel, 1'b0};
    end

    clkdiv_stage #(.RW(GEN_RW)) u_gen (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .in_tick  (1'b1),
        .in_lvl   (1'b1),
        .ratio    (gen_ratio),
        .out_tick (gen_tick),
        .out_lvl  (gen_clk)
    );

    clkdiv_stage #(.RW(BUS_RW)) u_bus (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .in_tick  (gen_tick),
        .in_lvl   (gen_clk),
        .ratio    (bus_ratio),
        .out_tick (bus_tick),
        .out_lvl  (bus_clk)
    );

    clkdiv_extgate u_ext (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .src_tick (bus_tick),
        .src_lvl  (bus_clk),
        .ena      (ext_en),
        .locked   (pll_locked),
        .ext_lvl  (ext_clk),
        .ext_tick (ext_tick)
    );

    clkdiv_stage #(.RW(BAUD_RW)) u_baud (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .in_tick  (1'b1),
        .in_lvl   (1'b1),
        .ratio    (baud_ratio),
        .out_tick (baud_tick),
        .out_lvl  (baud_clk)
    );

endmodule

// File: rtl/sysclk_div_tree_chk.sv
// Property checker for the divider tree, attached to every instance by bind.
module sysclk_div_tree_chk (
    input logic clk_vco,
    input logic rst_n,
    input logic pll_locked,
    input logic gen_clk,
    input logic gen_tick,
    input logic bus_clk,
    input logic bus_tick,
    input logic ext_clk,
    input logic ext_tick,
    input logic baud_clk,
    input logic baud_tick
);

    AST_GEN_TICK_HIGH: assert property (@(posedge clk_vco) disable iff (!rst_n)
        gen_tick |-> gen_clk); // R11
    AST_BUS_TICK_HIGH: assert property (@(posedge clk_vco) disable iff (!rst_n)
        bus_tick |-> bus_clk); // R11
    AST_BAUD_TICK_HIGH: assert property (@(posedge clk_vco) disable iff (!rst_n)
        baud_tick |-> baud_clk); // R11
    AST_EXT_TICK_HIGH: assert property (@(posedge clk_vco) disable iff (!rst_n)
        ext_tick |-> ext_clk); // R11
    AST_BUS_AFTER_GEN: assert property (@(posedge clk_vco) disable iff (!rst_n)
        bus_tick |-> $past(gen_tick)); // R3
    AST_EXT_FOLLOWS_BUS: assert property (@(posedge clk_vco) disable iff (!rst_n)
        ext_clk |-> $past(bus_clk)); // R6
    AST_EXT_UNLOCK_LOW: assert property (@(posedge clk_vco) disable iff (!rst_n)
        !pll_locked |=> (!ext_clk && !ext_tick)); // R7
    AST_EXT_RELOCK_WAIT: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (!ext_clk && $stable(ext_clk) && !bus_tick) |=> !$rose(ext_clk)); // R8

endmodule

bind sysclk_div_tree sysclk_div_tree_chk u_chk (.*);

// File: tb/sysclk_div_tree_bench.sv
module sysclk_div_tree_bench;

    logic       clk_vco = 1'b0;
    logic       rst_n = 1'b0;
    logic       lowpwr_sel = 1'b0;
    logic [2:0] norm_exp = '0, lp_exp = '0;
    logic [1:0] bus_div = '0, baud_sel = '0;
    logic       ext_en = 1'b0, pll_locked = 1'b0;
    logic gen_clk, gen_tick, bus_clk, bus_tick, ext_clk, ext_tick, baud_clk, baud_tick;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk_vco = ~clk_vco;

    sysclk_div_tree u_sysclk_div_tree (.*);

    // Behavioural reference: index 0 gen, 1 bus, 2 baud.
    int pos[3], len[3];
    bit tk[3], lv[3];
    bit m_ext, m_etk, m_gate;

    task automatic step(input int i, input bit itk, input bit ilv, input int nl);
        if (itk) begin
            if (pos[i] == len[i] - 1) begin pos[i] = 0; len[i] = nl; tk[i] = 1; end
            else begin pos[i] = pos[i] + 1; tk[i] = 0; end
        end else tk[i] = 0;
        lv[i] = (len[i] == 1) ? ilv : (pos[i] < len[i] / 2);
    endtask

    always @(posedge clk_vco) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin pos[i] = 0; len[i] = 1; tk[i] = 0; lv[i] = 0; end
            m_ext = 0; m_etk = 0; m_gate = 0;
        end else begin
            bit otk, olv, btk, blv, use_g;
            otk = tk[0]; olv = lv[0]; btk = tk[1]; blv = lv[1];
            use_g = pll_locked && (btk ? ext_en : m_gate);
            m_ext = use_g && blv;
            m_etk = use_g && btk;
            m_gate = !pll_locked ? 0 : (btk ? ext_en : m_gate);
            step(1, otk, olv, bus_div + 1);
            step(0, 1, 1, lowpwr_sel ? (2 << lp_exp) : (1 << norm_exp));
            step(2, 1, 1, 1 << (2 * baud_sel));
        end
    end

    task automatic chk(input string req, input string nm, input bit act, input bit exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d actual %0b expected %0b", req, nm, cyc, act, exp);
        end
    endtask

    // Full compare on every falling edge.
    always @(negedge clk_vco) begin
        cyc++;
        chk(lowpwr_sel ? "R2" : "R1", "gen_tick", gen_tick, tk[0]);
        chk("R4", "gen_clk", gen_clk, lv[0]);
        chk("R3", "bus_tick", bus_tick, tk[1]);
        chk("R4", "bus_clk", bus_clk, lv[1]);
        chk("R6", "ext_clk", ext_clk, m_ext);
        chk("R11", "ext_tick", ext_tick, m_etk);
        chk("R9", "baud_tick", baud_tick, tk[2]);
        chk("R4", "baud_clk", baud_clk, lv[2]);
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk_vco);
    endtask

    task automatic count(input int n, output int g, output int b, output int e);
        g = 0; b = 0; e = 0;
        repeat (n) begin
            @(negedge clk_vco);
            g += gen_tick; b += baud_tick; e += ext_tick;
        end
    endtask

    task automatic expect_eq(input string req, input string nm, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0d expected %0d", req, nm, act, exp);
        end
    endtask

    task automatic wait_gen_tick;
        do @(negedge clk_vco); while (!gen_tick);
    endtask

    initial begin
        int g, b, e;
        cycles(3);
        expect_eq("R10", "outputs in reset", {gen_clk, gen_tick, bus_clk, bus_tick,
                  ext_clk, ext_tick, baud_clk, baud_tick}, 0);
        rst_n = 1'b1;
        cycles(1);
        expect_eq("R10", "first gen_tick", gen_tick, 1);
        expect_eq("R10", "first baud_tick", baud_tick, 1);
        cycles(40);
        // R1 normal-mode ratios
        for (int n = 0; n < 8; n++) begin
            norm_exp = 3'(n);
            cycles(300);
            count(512, g, b, e);
            expect_eq("R1", "gen ticks per 512", g, 512 >> n);
        end
        // R2 low-power ratios, R9 baud independent of mode
        lowpwr_sel = 1'b1;
        for (int l = 0; l < 8; l++) begin
            lp_exp = 3'(l);
            baud_sel = 2'(l % 4);
            cycles(300);
            count(512, g, b, e);
            expect_eq("R2", "gen ticks per 512", g, 512 >> (l + 1));
            expect_eq("R9", "baud ticks per 512", b, 512 >> (2 * (l % 4)));
        end
        // R5: change mid-period; the current 8-cycle period must finish
        lowpwr_sel = 1'b0; norm_exp = 3'd3;
        cycles(300);
        wait_gen_tick();
        cycles(2);
        norm_exp = 3'd0;
        count(5, g, b, e);
        expect_eq("R5", "no early gen tick", g, 0);
        count(8, g, b, e);
        expect_eq("R5", "new ratio after boundary", g, 8);
        // R3/R4 bus ratios including odd and ratio 1 at both stages
        pll_locked = 1'b1; ext_en = 1'b1;
        for (int bd = 0; bd < 4; bd++) begin
            for (int n = 0; n < 3; n++) begin
                bus_div = 2'(bd); norm_exp = 3'(n);
                cycles(100);
            end
        end
        // R8: disable mid-period, ext must finish then stay low
        bus_div = 2'd3; norm_exp = 3'd2;
        cycles(100);
        wait_gen_tick();
        cycles(3);
        ext_en = 1'b0;
        cycles(40);
        count(64, g, b, e);
        expect_eq("R8", "ext ticks after disable", e, 0);
        ext_en = 1'b1;
        cycles(40);
        // R7: drop lock while running, relock mid-period
        pll_locked = 1'b0;
        cycles(1);
        count(30, g, b, e);
        expect_eq("R7", "ext ticks while unlocked", e, 0);
        expect_eq("R7", "ext level while unlocked", ext_clk, 0);
        pll_locked = 1'b1;
        cycles(7);
        pll_locked = 1'b0; cycles(3); pll_locked = 1'b1;
        cycles(200);
        // mixed mode switching with long low-power ratio
        lowpwr_sel = 1'b1; lp_exp = 3'd7; bus_div = 2'd2;
        cycles(2000);
        lowpwr_sel = 1'b0; norm_exp = 3'd1; bus_div = 2'd0;
        cycles(1500);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk_vco);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule